// File: doc/BRIEF.md
# Dual-Port Memory Bank Mapper with Configuration Register

This block sits between two serial-bus front ends and a shared 1 KB byte array. It holds the small configuration byte that shapes the host-facing port. It also turns each port access, made of a segment pointer and an 8-bit word offset, into a 10-bit physical array address. The display-facing port sees the whole array as one flat space of four 256-byte segments and may always write. The host-facing port sees only one of two 512-byte banks, each made of two segments. The bank is picked by register bits, by an external select pin, or by both. Host writes pass only when the register's write-enable bit is set.

The address and the write permit are combinational, so the front end can present an access and use the result in the same cycle. A register write takes effect on the next clock edge. The serial protocols and the array itself live outside this block.

Top module: `cfg_bank_mapper`

## Requirements
- R1: After reset the register readback `cfg_rd_data` is 8'hFF, which means NB=1 and WE=1.
- R2: When `cfg_wr_en` is high at a clock edge, bits 3:0 of `cfg_wr_data` are stored. From the next cycle the readback shows them in bits 3:0. Bits 7:4 always read as 1, whatever was written. The field positions are bit 3 = WE (host write enable), bit 2 = AB1, bit 1 = AB0 and bit 0 = NB (single-bank mode).
- R3: With `port_host`=1 (host port) and NB=1, the lower bank is used (`phys_addr[9]`=0), whatever AB1, AB0 and `bank_pin` are.
- R4: With `port_host`=1, NB=0 and AB1=0, `bank_pin` picks the bank: 0 selects the lower bank and 1 selects the upper bank.
- R5: With `port_host`=1, NB=0 and AB1=1, AB0 picks the bank (0 lower, 1 upper) and `bank_pin` has no effect.
- R6: On the host port, `phys_addr` = {bank, `seg_ptr[0]`, `word_off`}. The upper bank is physical segments 2 and 3, and `seg_ptr[7:1]` have no effect.
- R7: With `port_host`=0 (display port), `phys_addr` = {`seg_ptr[1:0]`, `word_off`}. `seg_ptr[7:2]`, the register and `bank_pin` have no effect.
- R8: On the host port, `wr_permit` = `wr_req` AND WE.
- R9: On the display port, `wr_permit` = `wr_req`, whatever WE is.
- R10: An access presented in the same cycle as a register write is mapped and gated with the old register value. The new value applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_host | input | 1 | 1 = host-facing port access, 0 = display-facing port access |
| seg_ptr | input | 8 | Segment pointer of the accessing port |
| word_off | input | 8 | Byte offset within the segment |
| bank_pin | input | 1 | External bank-select pin |
| wr_req | input | 1 | Access is a write |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration register write data |
| cfg_rd_data | output | 8 | Configuration register readback |
| phys_addr | output | 10 | Physical array address |
| wr_permit | output | 1 | The write may proceed to the array |

## Verification
A register write and a host access can fall in the same cycle, and the mapper must resolve that access with the old setting. The bench provokes this at a clock low phase. It sets a register value that forces the lower bank with writes disabled, then drives a write to a new value that hands the choice to the pin and enables writes. In the same cycle it presents a host write with the pin high. The address and permit are judged twice: before the edge they must reflect the old value, and after the edge the new one.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
  // Field positions in the stored nibble: [3]=we [2]=ab1 [1]=ab0 [0]=nb
  typedef struct packed {
    logic we;
    logic ab1;
    logic ab0;
    logic nb;
  } cbm_cfg_t;

  localparam int CBM_CFG_BITS = 4;
  localparam cbm_cfg_t CBM_CFG_RESET = '{we: 1'b1, ab1: 1'b1, ab0: 1'b1, nb: 1'b1};
endpackage

// File: rtl/cbm_cfg_reg.sv
`timescale 1ns/1ps
module cbm_cfg_reg
  import cbm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cbm_cfg_t         cfg_q,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - CBM_CFG_BITS;

  cbm_cfg_t cfg_n;
  logic     unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:CBM_CFG_BITS];

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      cfg_n = cbm_cfg_t'(wr_data[CBM_CFG_BITS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CBM_CFG_RESET;
    end else if (wr_en) begin
      cfg_q <= cfg_n;
    end
  end

  // Unstored upper bits read back as ones, matching the erased state.
  assign rd_data = {{PAD_W{1'b1}}, cfg_q};
endmodule

// File: rtl/cbm_bank_sel.sv
`timescale 1ns/1ps
module cbm_bank_sel
  import cbm_pkg::*;
(
  input  cbm_cfg_t cfg,
  input  logic     pin,
  output logic     bank_upper
);
  always_comb begin
    if (cfg.nb) begin
      bank_upper = 1'b0;
    end else if (cfg.ab1) begin
      bank_upper = cfg.ab0;
    end else begin
      bank_upper = pin;
    end
  end
endmodule

// File: rtl/cbm_addr_map.sv
`timescale 1ns/1ps
module cbm_addr_map #(
  parameter int PTR_W     = 8,
  parameter int OFF_W     = 8,
  parameter int DISP_SEGB = 2
) (
  input  logic                       is_host,
  input  logic                       bank_upper,
  input  logic [PTR_W-1:0]           seg,
  input  logic [OFF_W-1:0]           off,
  output logic [DISP_SEGB+OFF_W-1:0] addr
);
  localparam int HOST_SEGB = DISP_SEGB - 1;
  localparam int ADDR_W    = DISP_SEGB + OFF_W;

  logic [ADDR_W-1:0] host_addr;
  logic [ADDR_W-1:0] disp_addr;
  logic              unused_seg;

  generate
    if (PTR_W > DISP_SEGB) begin : g_wide_ptr
      assign unused_seg = ^seg[PTR_W-1:DISP_SEGB];
    end else begin : g_narrow_ptr
      assign unused_seg = 1'b0;
    end
  endgenerate

  assign host_addr = {bank_upper, seg[HOST_SEGB-1:0], off};
  assign disp_addr = {seg[DISP_SEGB-1:0], off};

  always_comb begin
    if (is_host) begin
      addr = host_addr;
    end else begin
      addr = disp_addr;
    end
  end
endmodule

// File: rtl/cbm_write_gate.sv
`timescale 1ns/1ps
module cbm_write_gate (
  input  logic is_host,
  input  logic we,
  input  logic wr_req,
  output logic permit
);
  always_comb begin
    permit = wr_req & (~is_host | we);
  end
endmodule

// File: rtl/cfg_bank_mapper.sv
`timescale 1ns/1ps
module cfg_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int OFF_W     = 8,
  parameter int REG_W     = 8,
  parameter int DISP_SEGB = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       port_host,
  input  logic [PTR_W-1:0]           seg_ptr,
  input  logic [OFF_W-1:0]           word_off,
  input  logic                       bank_pin,
  input  logic                       wr_req,
  input  logic                       cfg_wr_en,
  input  logic [REG_W-1:0]           cfg_wr_data,
  output logic [REG_W-1:0]           cfg_rd_data,
  output logic [DISP_SEGB+OFF_W-1:0] phys_addr,
  output logic                       wr_permit
);
  cbm_cfg_t cfg;
  logic     bank_upper;

  cbm_cfg_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg),
    .rd_data (cfg_rd_data)
  );

  cbm_bank_sel u_bank (
    .cfg        (cfg),
    .pin        (bank_pin),
    .bank_upper (bank_upper)
  );

  cbm_addr_map #(.PTR_W(PTR_W), .OFF_W(OFF_W), .DISP_SEGB(DISP_SEGB)) u_map (
    .is_host    (port_host),
    .bank_upper (bank_upper),
    .seg        (seg_ptr),
    .off        (word_off),
    .addr       (phys_addr)
  );

  cbm_write_gate u_gate (
    .is_host (port_host),
    .we      (cfg.we),
    .wr_req  (wr_req),
    .permit  (wr_permit)
  );
endmodule

// File: rtl/cbm_checker.sv
`timescale 1ns/1ps
module cbm_checker #(
  parameter int PTR_W     = 8,
  parameter int OFF_W     = 8,
  parameter int REG_W     = 8,
  parameter int DISP_SEGB = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       port_host,
  input logic [PTR_W-1:0]           seg_ptr,
  input logic [OFF_W-1:0]           word_off,
  input logic                       bank_pin,
  input logic                       wr_req,
  input logic                       cfg_wr_en,
  input logic [REG_W-1:0]           cfg_wr_data,
  input logic [REG_W-1:0]           cfg_rd_data,
  input logic [DISP_SEGB+OFF_W-1:0] phys_addr,
  input logic                       wr_permit
);
  localparam int ADDR_W = DISP_SEGB + OFF_W;

  logic seen_wr;
  logic unused_pin;
  assign unused_pin = bank_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr <= 1'b0;
    end else if (cfg_wr_en) begin
      seen_wr <= 1'b1;
    end
  end

  a_r1_reset_readback: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> cfg_rd_data == {REG_W{1'b1}});

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == {{(REG_W-4){1'b1}}, $past(cfg_wr_data[3:0])});

  a_r3_single_bank_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (port_host && cfg_rd_data[0]) |-> !phys_addr[ADDR_W-1]);

  a_r6_host_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    port_host |-> (phys_addr[OFF_W-1:0] == word_off && phys_addr[OFF_W] == seg_ptr[0]));

  a_r7_display_flat: assert property (@(posedge clk) disable iff (!rst_n)
    !port_host |-> phys_addr == {seg_ptr[DISP_SEGB-1:0], word_off});

  a_r8_host_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (port_host && !cfg_rd_data[3]) |-> !wr_permit);

  a_r9_display_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !port_host |-> wr_permit == wr_req);
endmodule

bind cfg_bank_mapper cbm_checker #(
  .PTR_W(PTR_W), .OFF_W(OFF_W), .REG_W(REG_W), .DISP_SEGB(DISP_SEGB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_host   (port_host),
  .seg_ptr     (seg_ptr),
  .word_off    (word_off),
  .bank_pin    (bank_pin),
  .wr_req      (wr_req),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .phys_addr   (phys_addr),
  .wr_permit   (wr_permit)
);

// File: tb/cfg_bank_mapper_test.sv
`timescale 1ns/1ps
module cfg_bank_mapper_test;
  logic       clk;
  logic       rst_n;
  logic       port_host;
  logic [7:0] seg_ptr;
  logic [7:0] word_off;
  logic       bank_pin;
  logic       wr_req;
  logic       cfg_wr_en;
  logic [7:0] cfg_wr_data;
  logic [7:0] cfg_rd_data;
  logic [9:0] phys_addr;
  logic       wr_permit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cfg_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .port_host(port_host), .seg_ptr(seg_ptr),
    .word_off(word_off), .bank_pin(bank_pin), .wr_req(wr_req),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .phys_addr(phys_addr), .wr_permit(wr_permit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_addr(input logic [3:0] c, input logic host,
                                          input logic pin, input logic [7:0] s,
                                          input logic [7:0] o);
    logic bank;
    bank = c[0] ? 1'b0 : (c[2] ? c[1] : pin);
    return host ? {bank, s[0], o} : {s[1:0], o};
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(posedge clk);
    #1;
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; port_host = 1'b0; seg_ptr = '0; word_off = '0; bank_pin = 1'b0;
    wr_req = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset readback, and its effect: single bank, host writes enabled
    @(negedge clk);
    port_host = 1'b1; bank_pin = 1'b1; seg_ptr = 8'h01; word_off = 8'h33; wr_req = 1'b1;
    #1;
    chk(cfg_rd_data == 8'hFF, "R1 readback", cfg_rd_data, 8'hFF);
    chk(phys_addr == 10'h133, "R1 R3 reset bank", phys_addr, 10'h133);
    chk(wr_permit == 1'b1, "R1 R8 reset we", wr_permit, 1);

    // Sweep all register settings against port, pin, segment, offset, write
    for (int c = 0; c < 16; c++) begin
      logic [7:0] wv;
      wv = {4'(c * 5 + 3), 4'(c)};
      write_cfg(wv);
      chk(cfg_rd_data == {4'hF, 4'(c)}, "R2 readback", cfg_rd_data, {4'hF, 4'(c)});
      for (int h = 0; h < 2; h++)
        for (int p = 0; p < 2; p++)
          for (int si = 0; si < 10; si++)
            for (int oi = 0; oi < 3; oi++)
              for (int w = 0; w < 2; w++) begin
                logic [7:0] s, o;
                logic [9:0] ea;
                logic       ep;
                string      ta, tp;
                s = (si < 8) ? 8'(si) : ((si == 8) ? 8'hFE : 8'h81);
                o = (oi == 0) ? 8'h00 : ((oi == 1) ? 8'h5A : 8'hFF);
                @(negedge clk);
                port_host = h[0]; bank_pin = p[0]; seg_ptr = s; word_off = o; wr_req = w[0];
                #1;
                ea = exp_addr(4'(c), h[0], p[0], s, o);
                ep = w[0] & (~h[0] | c[3]);
                // host-port address form is R6 in every host case
                if (h == 0)      ta = "R7 display addr";
                else if (c[0])   ta = "R3 R6 host addr";
                else if (c[2])   ta = "R5 R6 host addr";
                else             ta = "R4 R6 host addr";
                tp = h[0] ? "R8 host permit" : "R9 display permit";
                chk(phys_addr == ea, ta, phys_addr, ea);
                chk(wr_permit == ep, tp, wr_permit, ep);
              end
    end

    // R10: register write and host access in the same cycle
    write_cfg(8'h01);                 // NB=1, WE=0
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 8'h08;   // NB=0, AB1=0, WE=1: pin picks bank
    port_host = 1'b1; bank_pin = 1'b1; seg_ptr = 8'h00; word_off = 8'h10; wr_req = 1'b1;
    #1;
    chk(phys_addr == 10'h010, "R10 old bank same cycle", phys_addr, 10'h010);
    chk(wr_permit == 1'b0, "R10 old we same cycle", wr_permit, 0);
    @(posedge clk);
    #1;
    cfg_wr_en = 1'b0;
    chk(phys_addr == 10'h210, "R10 new bank next cycle", phys_addr, 10'h210);
    chk(wr_permit == 1'b1, "R10 new we next cycle", wr_permit, 1);
    chk(cfg_rd_data == 8'hF8, "R2 R10 readback", cfg_rd_data, 8'hF8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule